// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers fifteen interrupt sources, numbered 1 through 15, and presents a single 4-bit request code to one processor. Every source passes through a per-processor enable mask and can also be raised by software through a force register. Each source is assigned to a high or a low priority class. All high-class candidates are served before any low-class candidate. Within the winning class, the highest-numbered source is reported.

Software reaches the controller over a 32-bit word register bus. Only byte address bits 7..2 reach the block. Reads are combinational from the current register state, and writes take effect on the clock edge where the write enable is sampled. The processor retires a taken interrupt by presenting its number on the acknowledge port. Several banks of per-processor mask, force and extension registers exist. Only bank 0 takes part in request generation; the other banks are plain storage.

External sources are synchronous active-high inputs, sampled on every cycle. A source marked for broadcast is recorded in the force register of every bank instead of in the pending register.

Top module: `prio_intc`

## Requirements
- R1: After reset every register reads as zero and `irl_o` is 0.
- R2: Global registers sit at byte offsets 0x00 (class select), 0x04 (pending), 0x08 (bank-0 force alias), 0x0C (clear), 0x10 (status) and 0x14 (broadcast). Bank c has its mask at 0x40+4c, its force at 0x80+4c and its extension at 0xC0+4c. The following all read as 0 and ignore writes: the clear and status registers, offsets 0x18 to 0x3C, and any bank at or beyond NUM_CPU.
- R3: Bit 0 is never stored. The class select, broadcast, mask and force registers keep bits 15:1 of a write. Extension registers keep bits 3:0.
- R4: `irl_o` shows the index of the highest set bit of the winning candidate set, or 0 when that set is empty. It changes one clock edge after the state change that causes it. The active set is (pending OR bank-0 force) AND bank-0 mask.
- R5: A source whose class-select bit is 1 is high class. If any active high-class source exists, only high-class sources are considered, even when a low-class source has a higher number.
- R6: A write to bank force register c sets the bits given in data[15:1] and clears the bits given in data[31:17], so that data bit 16+k clears source k. A clear takes precedence over a set of the same bit. Each bank's force register is independent of the others.
- R7: A write to offset 0x08 replaces the bank-0 force register with data[15:1]. A read at 0x08 returns the bank-0 force register.
- R8: A write to the clear register removes the written source bits from both the pending register and the bank-0 force register.
- R9: Writes to the pending and status registers leave all state unchanged.
- R10: A high input `irq_i[k]` (k from 1 to 15) sets pending bit k when broadcast bit k is 0. When broadcast bit k is 1, it instead sets bit k in the force register of every bank. `irq_i[0]` has no effect.
- R11: An acknowledge with number n clears bit n of both the pending register and the bank-0 force register.
- R12: A source input that is high in the same cycle as a clear or an acknowledge of the same bit leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address bits 7..2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_i | input | 16 | Source inputs, bit k is source k, bit 0 unused |
| ack_en_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 4 | Number of the acknowledged source |
| irl_o | output | 4 | Registered request code, 0 means none |

## Verification
A corrupted pending, force or mask bit shows up two ways. It is visible at once as a wrong register read, and one edge later as a wrong `irl_o` code, so every check samples the request one cycle after the stimulus. A wrong class decision only shows when a low-class source outnumbers a high-class one. For that reason the stimulus arranges the low-class source to carry the larger number. Bank independence and broadcast fan-out are observed by reading every bank's force register after a single event.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NLINES = 16;
  typedef logic [NLINES-1:0] line_vec_t;
  localparam line_vec_t LINE_MASK = 16'hFFFE;

  // word indices (byte offset >> 2)
  localparam logic [5:0] W_LEVEL  = 6'h00;
  localparam logic [5:0] W_PEND   = 6'h01;
  localparam logic [5:0] W_FALIAS = 6'h02;
  localparam logic [5:0] W_CLEAR  = 6'h03;
  localparam logic [5:0] W_STATUS = 6'h04;
  localparam logic [5:0] W_BCAST  = 6'h05;

  localparam logic [1:0] SEG_GLOBAL = 2'b00;
  localparam logic [1:0] SEG_MASK   = 2'b01;
  localparam logic [1:0] SEG_FORCE  = 2'b10;
  localparam logic [1:0] SEG_EXT    = 2'b11;

  localparam int unsigned EXT_W = 4;

  function automatic logic [3:0] top_index(input line_vec_t v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 0; i < NLINES; i++) begin
      if (v[i]) r = 4'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/intc_force_bank.sv
module intc_force_bank
  import intc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bank_we_i,
  input  line_vec_t set_i,
  input  line_vec_t clr_i,
  input  logic      alias_we_i,
  input  line_vec_t alias_val_i,
  input  line_vec_t drop_i,
  input  line_vec_t bcast_set_i,
  output line_vec_t force_o
);
  line_vec_t force_q, force_d;

  always_comb begin
    force_d = force_q;
    if (bank_we_i)  force_d = (force_d | set_i) & ~clr_i;
    if (alias_we_i) force_d = alias_val_i;
    force_d = force_d & ~drop_i;
    force_d = (force_d | bcast_set_i) & LINE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) force_q <= '0;
    else         force_q <= force_d;
  end

  assign force_o = force_q;

  // clear half beats set half unless a broadcast event re-sets the bit
  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_i && ((clr_i & ~bcast_set_i) != '0))
      |=> ((force_q & $past(clr_i & ~bcast_set_i)) == '0));
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:2]  addr_i,
  input  logic [31:0] wdata_i,
  input  line_vec_t   irq_i,
  input  logic        ack_en_i,
  input  logic [3:0]  ack_id_i,
  output logic [31:0] rdata_o,
  output line_vec_t   pending_o,
  output line_vec_t   force0_o,
  output line_vec_t   mask0_o,
  output line_vec_t   level_o
);
  localparam int unsigned IDX_W = 4;

  logic [1:0]       seg;
  logic [IDX_W-1:0] idx;
  assign seg = addr_i[7:6];
  assign idx = addr_i[5:2];

  logic wr_level, wr_falias, wr_clear, wr_bcast;
  assign wr_level  = wr_en_i && (addr_i == W_LEVEL);
  assign wr_falias = wr_en_i && (addr_i == W_FALIAS);
  assign wr_clear  = wr_en_i && (addr_i == W_CLEAR);
  assign wr_bcast  = wr_en_i && (addr_i == W_BCAST);

  line_vec_t wvec, wclr;
  assign wvec = wdata_i[15:0]  & LINE_MASK;
  assign wclr = wdata_i[31:16] & LINE_MASK;

  line_vec_t level_q, pending_q, bcast_q;
  line_vec_t mask_q  [NUM_CPU];
  logic [EXT_W-1:0] ext_q [NUM_CPU];
  line_vec_t force_q [NUM_CPU];

  line_vec_t irq_set, bcast_hit, pend_hit, drop;
  assign irq_set   = irq_i & LINE_MASK;
  assign bcast_hit = irq_set & bcast_q;
  assign pend_hit  = irq_set & ~bcast_q;
  assign drop = ((wr_clear ? wvec : '0) |
                 (ack_en_i ? (line_vec_t'(1) << ack_id_i) : '0)) & LINE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q   <= '0;
      pending_q <= '0;
      bcast_q   <= '0;
    end else begin
      if (wr_level) level_q <= wvec;
      if (wr_bcast) bcast_q <= wvec;
      // set after clear: a same-cycle source event survives
      pending_q <= (pending_q & ~drop) | pend_hit;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic wr_mask, wr_force, wr_ext;
    assign wr_mask  = wr_en_i && (seg == SEG_MASK)  && (idx == IDX_W'(c));
    assign wr_force = wr_en_i && (seg == SEG_FORCE) && (idx == IDX_W'(c));
    assign wr_ext   = wr_en_i && (seg == SEG_EXT)   && (idx == IDX_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[c] <= '0;
        ext_q[c]  <= '0;
      end else begin
        if (wr_mask) mask_q[c] <= wvec;
        if (wr_ext)  ext_q[c]  <= wdata_i[EXT_W-1:0];
      end
    end

    if (c == 0) begin : g_primary
      intc_force_bank u_force (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bank_we_i   (wr_force),
        .set_i       (wvec),
        .clr_i       (wclr),
        .alias_we_i  (wr_falias),
        .alias_val_i (wvec),
        .drop_i      (drop),
        .bcast_set_i (bcast_hit),
        .force_o     (force_q[c])
      );
    end else begin : g_storage
      intc_force_bank u_force (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bank_we_i   (wr_force),
        .set_i       (wvec),
        .clr_i       (wclr),
        .alias_we_i  (1'b0),
        .alias_val_i ('0),
        .drop_i      ('0),
        .bcast_set_i (bcast_hit),
        .force_o     (force_q[c])
      );
    end
  end

  always_comb begin
    rdata_o = '0;
    case (seg)
      SEG_GLOBAL: begin
        case (addr_i)
          W_LEVEL:  rdata_o = {16'h0, level_q};
          W_PEND:   rdata_o = {16'h0, pending_q};
          W_FALIAS: rdata_o = {16'h0, force_q[0]};
          W_BCAST:  rdata_o = {16'h0, bcast_q};
          default:  rdata_o = '0;
        endcase
      end
      SEG_MASK: begin
        for (int c = 0; c < NUM_CPU; c++)
          if (idx == IDX_W'(c)) rdata_o = {16'h0, mask_q[c]};
      end
      SEG_FORCE: begin
        for (int c = 0; c < NUM_CPU; c++)
          if (idx == IDX_W'(c)) rdata_o = {16'h0, force_q[c]};
      end
      default: begin
        for (int c = 0; c < NUM_CPU; c++)
          if (idx == IDX_W'(c)) rdata_o = {{(32-EXT_W){1'b0}}, ext_q[c]};
      end
    endcase
  end

  assign pending_o = pending_q;
  assign force0_o  = force_q[0];
  assign mask0_o   = mask_q[0];
  assign level_o   = level_q;

  assert_pend_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == W_PEND) && !ack_en_i && (irq_set == '0))
      |=> $stable(pending_q));

  assert_ack_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_en_i && !irq_set[ack_id_i])
      |=> (((pending_q >> $past(ack_id_i)) & 16'h1) == 16'h0));

  assert_bcast_fanout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_hit != '0) |=> ((force_q[0] & $past(bcast_hit)) == $past(bcast_hit)));

  assert_set_beats_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_hit & drop) != '0) |=> ((pending_q & $past(pend_hit)) == $past(pend_hit)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  line_vec_t  pending_i,
  input  line_vec_t  force0_i,
  input  line_vec_t  mask0_i,
  input  line_vec_t  level_i,
  output logic [3:0] irl_o
);
  line_vec_t active, cand_hi, cand_lo, winner;
  logic [3:0] irl_q;

  assign active  = (pending_i | force0_i) & mask0_i & LINE_MASK;
  assign cand_hi = active & level_i;
  assign cand_lo = active & ~level_i;
  assign winner  = (cand_hi != '0) ? cand_hi : cand_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irl_q <= '0;
    else         irl_q <= top_index(winner);
  end

  assign irl_o = irl_q;

  assert_hi_class_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_hi != '0) |=> (((($past(level_i) & $past(active)) >> irl_o) & 16'h1) == 16'h1));

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |=> (irl_o == 4'd0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:2]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [15:0] irq_i,
  input  logic        ack_en_i,
  input  logic [3:0]  ack_id_i,
  output logic [3:0]  irl_o
);
  line_vec_t pending, force0, mask0, level;

  intc_regfile #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .irq_i     (irq_i),
    .ack_en_i  (ack_en_i),
    .ack_id_i  (ack_id_i),
    .rdata_o   (rdata_o),
    .pending_o (pending),
    .force0_o  (force0),
    .mask0_o   (mask0),
    .level_o   (level)
  );

  intc_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .force0_i  (force0),
    .mask0_i   (mask0),
    .level_i   (level),
    .irl_o     (irl_o)
  );
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq = '0;
  logic        ack_en = 1'b0;
  logic [3:0]  ack_id = '0;
  logic [3:0]  irl;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  prio_intc #(.NUM_CPU(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr[7:2]),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .ack_en_i(ack_en),
    .ack_id_i(ack_id), .irl_o(irl)
  );

  localparam logic [1:0] W = 2'd0, R = 2'd1, I = 2'd2, P = 2'd3;
  localparam int N = 63;
  // {kind, byte address, data or expected value, requirement}
  localparam logic [45:0] VEC [N] = '{
    {R, 8'h00, 32'h0000_0000, 4'd1},  // R1
    {R, 8'h04, 32'h0000_0000, 4'd1},
    {I, 8'h00, 32'h0000_0000, 4'd1},
    {W, 8'h00, 32'hFFFF_FFFF, 4'd3},  // R3 class select width
    {R, 8'h00, 32'h0000_FFFE, 4'd3},
    {W, 8'h00, 32'h0000_0000, 4'd3},
    {W, 8'h14, 32'hFFFF_FFFF, 4'd3},
    {R, 8'h14, 32'h0000_FFFE, 4'd3},
    {W, 8'h14, 32'h0000_0000, 4'd3},
    {W, 8'hC4, 32'hFFFF_FFFF, 4'd3},
    {R, 8'hC4, 32'h0000_000F, 4'd3},
    {W, 8'hD0, 32'hFFFF_FFFF, 4'd2},  // R2 bank beyond count
    {R, 8'hD0, 32'h0000_0000, 4'd2},
    {W, 8'h50, 32'hFFFF_FFFF, 4'd2},
    {R, 8'h50, 32'h0000_0000, 4'd2},
    {W, 8'h18, 32'hFFFF_FFFF, 4'd2},
    {R, 8'h18, 32'h0000_0000, 4'd2},
    {W, 8'h40, 32'h0000_FFFF, 4'd3},
    {R, 8'h40, 32'h0000_FFFE, 4'd3},
    {P, 8'h00, 32'h0000_0028, 4'd10}, // R10 sources 3 and 5
    {R, 8'h04, 32'h0000_0028, 4'd10},
    {I, 8'h00, 32'h0000_0005, 4'd4},  // R4
    {W, 8'h00, 32'h0000_0008, 4'd5},  // R5 source 3 high class
    {I, 8'h00, 32'h0000_0003, 4'd5},
    {W, 8'h0C, 32'h0000_0008, 4'd8},  // R8
    {R, 8'h04, 32'h0000_0020, 4'd8},
    {I, 8'h00, 32'h0000_0005, 4'd8},
    {W, 8'h04, 32'hFFFF_FFFF, 4'd9},  // R9
    {R, 8'h04, 32'h0000_0020, 4'd9},
    {W, 8'h10, 32'hFFFF_FFFF, 4'd9},
    {R, 8'h10, 32'h0000_0000, 4'd2},
    {R, 8'h0C, 32'h0000_0000, 4'd2},
    {W, 8'h80, 32'h0004_0300, 4'd6},  // R6 set 9,8
    {R, 8'h08, 32'h0000_0300, 4'd6},
    {I, 8'h00, 32'h0000_0009, 4'd4},
    {W, 8'h80, 32'h0200_0002, 4'd6},  // set 1, clear 9
    {R, 8'h80, 32'h0000_0102, 4'd6},
    {W, 8'h80, 32'h0040_0040, 4'd6},  // set and clear 6
    {R, 8'h80, 32'h0000_0102, 4'd6},
    {W, 8'h08, 32'h0000_8001, 4'd7},  // R7
    {R, 8'h80, 32'h0000_8000, 4'd7},
    {I, 8'h00, 32'h0000_000F, 4'd4},
    {W, 8'h00, 32'h0000_0020, 4'd5},
    {I, 8'h00, 32'h0000_0005, 4'd5},
    {W, 8'h40, 32'h0000_7FFE, 4'd4},
    {I, 8'h00, 32'h0000_0005, 4'd5},
    {W, 8'h00, 32'h0000_0000, 4'd4},
    {I, 8'h00, 32'h0000_0005, 4'd4},
    {W, 8'h40, 32'h0000_8000, 4'd4},
    {I, 8'h00, 32'h0000_000F, 4'd4},
    {W, 8'h40, 32'h0000_0000, 4'd4},
    {I, 8'h00, 32'h0000_0000, 4'd4},
    {W, 8'h14, 32'h0000_0400, 4'd10}, // broadcast source 10
    {P, 8'h00, 32'h0000_0400, 4'd10},
    {R, 8'h80, 32'h0000_8400, 4'd10},
    {R, 8'h84, 32'h0000_0400, 4'd10},
    {R, 8'h8C, 32'h0000_0400, 4'd10},
    {R, 8'h04, 32'h0000_0020, 4'd10},
    {W, 8'h84, 32'h0000_0010, 4'd6},
    {R, 8'h84, 32'h0000_0410, 4'd6},
    {R, 8'h88, 32'h0000_0400, 4'd6},
    {W, 8'h90, 32'hFFFF_FFFF, 4'd2},
    {R, 8'h90, 32'h0000_0000, 4'd2}
  };

  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic [15:0] src, input logic ak, input logic [3:0] id);
    @(negedge clk);
    addr = a; wr_en = we; wdata = d; irq = src; ack_en = ak; ack_id = id;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; irq = '0; ack_en = 1'b0; ack_id = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input int req);
    addr = a;
    #1;
    n_run++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d read 0x%02h: got 0x%08h expected 0x%08h", req, a, rdata, exp);
    end
  endtask

  task automatic irl_chk(input logic [3:0] exp, input int req);
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (irl !== exp) begin
      n_fail++;
      $display("FAIL R%0d irl: got %0d expected %0d", req, irl, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int k = 0; k < N; k++) begin
      logic [1:0]  kind;
      logic [7:0]  va;
      logic [31:0] vd;
      int          vr;
      kind = VEC[k][45:44];
      va   = VEC[k][43:36];
      vd   = VEC[k][35:4];
      vr   = int'(VEC[k][3:0]);
      case (kind)
        W: step(va, 1'b1, vd, 16'h0, 1'b0, 4'd0);
        R: rd_chk(va, vd, vr);
        I: irl_chk(vd[3:0], vr);
        default: step(8'h00, 1'b0, 32'h0, vd[15:0], 1'b0, 4'd0);
      endcase
    end

    // R11: acknowledge clears pending and bank-0 force
    step(8'h40, 1'b1, 32'h0000_FFFE, 16'h0, 1'b0, 4'd0);
    step(8'h00, 1'b0, 32'h0, 16'h0, 1'b1, 4'd5);
    rd_chk(8'h04, 32'h0000_0000, 11);
    step(8'h00, 1'b0, 32'h0, 16'h0, 1'b1, 4'd15);
    rd_chk(8'h08, 32'h0000_0400, 11);
    irl_chk(4'd10, 11);
    step(8'h00, 1'b0, 32'h0, 16'h0, 1'b1, 4'd10);
    irl_chk(4'd0, 11);

    // R12: same-cycle source event beats acknowledge and clear
    step(8'h00, 1'b0, 32'h0, 16'h0080, 1'b1, 4'd7);
    rd_chk(8'h04, 32'h0000_0080, 12);
    step(8'h0C, 1'b1, 32'h0000_0008, 16'h0008, 1'b0, 4'd0);
    rd_chk(8'h04, 32'h0000_0088, 12);
    irl_chk(4'd7, 12);

    // R10: input bit 0 has no effect
    step(8'h00, 1'b0, 32'h0, 16'h0001, 1'b0, 4'd0);
    rd_chk(8'h04, 32'h0000_0088, 10);
    rd_chk(8'h80, 32'h0000_0000, 10);

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    rd_chk(8'h04, 32'h0, 1);
    rd_chk(8'h40, 32'h0, 1);
    rd_chk(8'h14, 32'h0, 1);
    rd_chk(8'hC4, 32'h0, 1);
    n_run++;
    if (irl !== 4'd0) begin
      n_fail++;
      $display("FAIL R1 irl after reset: got %0d expected 0", irl);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    irl_chk(4'd0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule